// File: doc/BRIEF.md
# Debug-Aware Low-Power Clock Controller

This block keeps a debugger in control of a core that enters low-power states. It holds a small debug configuration word, reached through a 32-bit peripheral access port. The word is cleared only by power-on reset, so a system reset leaves a debugger's settings in place. The word carries three low-power debug enables (sleep, stop, standby), a trace pin enable and a two-bit trace mode.

The core reports its low-power state on a two-bit input. From that state and the enables, a policy decides two things: whether the gated core clock and bus clock run, and whether they come from the system clock or from the internal RC oscillator. A source change passes through a glitch-free two-leg switch. Each leg is disabled on its own falling edge and only then releases the other leg. Each clock gate is retimed on the falling edge of the selected clock.

The block also produces one freeze line per peripheral counter. A freeze line is high when the core is halted at a breakpoint and that counter has been set to stop. A counter whose configuration bit is clear keeps counting, for example one that generates PWM.

Top module: `lpdbg_clkctl`

## Requirements
- R1: Power-on reset (`por_n` low) clears the configuration word to zero; a word read then returns 0.
- R2: System reset (`sys_rst_n` low) leaves the configuration word unchanged, and word writes made while system reset is held are stored.
- R3: Only word accesses (`cfg_size` = 2) are honoured. A byte (0) or halfword (1) write leaves the word unchanged. Any narrow access raises `cfg_err` and reads 0. A word access keeps `cfg_err` low.
- R4: The bits of the configuration word are: bit 0 sleep enable, bit 1 stop enable, bit 2 standby enable, bit 5 trace pin enable, bits 7:6 trace mode. All other bits are stored as 0 and read as 0. `trace_en` and `trace_mode` follow bits 5 and 7:6.
- R5: In run (`lp_state` = 0), the core clock and the bus clock both run from `sys_clk`, and `clk_src` is 0.
- R6: In sleep (`lp_state` = 1), the bus clock runs from `sys_clk`. The core clock is stopped when the sleep enable is clear and runs from `sys_clk` when it is set.
- R7: In stop (`lp_state` = 2), both clocks are stopped when the stop enable is clear. When it is set, both run from `rc_clk` and `clk_src` is 1.
- R8: In standby (`lp_state` = 3), the same rule as R7 applies, governed by the standby enable.
- R9: The two source legs are never enabled together. Leaving a state that used `rc_clk` returns both clocks to `sys_clk` with `clk_src` 0.
- R10: `frz_out[i]` equals `frz_cfg[i]` ANDed with `core_halted` synchronised to `dbg_clk`. It settles within SYNC_STAGES+1 `dbg_clk` cycles and is 0 while system reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dbg_clk | input | 1 | Free-running clock for the access port and the freeze synchroniser |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low, asynchronous |
| sys_clk | input | 1 | System clock source |
| rc_clk | input | 1 | Internal RC oscillator source |
| cfg_sel | input | 1 | Access strobe for the configuration word |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data (0 unless a word access is selected) |
| cfg_err | output | 1 | Error response for a narrow access |
| lp_state | input | 2 | Core state: 0 run, 1 sleep, 2 stop, 3 standby |
| core_halted | input | 1 | Core halted at a breakpoint (asynchronous) |
| frz_cfg | input | NUM_FRZ | Per-counter freeze-on-halt selection |
| core_clk | output | 1 | Gated core clock |
| bus_clk | output | 1 | Gated bus clock |
| clk_src | output | 1 | Source in use: 0 sys_clk, 1 rc_clk |
| trace_en | output | 1 | Trace pin enable |
| trace_mode | output | 2 | Trace mode field |
| frz_out | output | NUM_FRZ | Freeze lines to peripheral counters |

## Verification
A corrupted configuration word shows up at once on a word read and on `trace_en`/`trace_mode`. It also shows one state change later as a clock that runs when it should stop, or from the wrong source. A switch leg stuck on or off appears within a few source cycles, as an edge count on `core_clk` or `bus_clk` that matches neither oscillator, or as a wrong `clk_src`. A freeze synchroniser that is too short, too long or reset by the wrong domain moves the change of `frz_out` away from cycle SYNC_STAGES+1. It can also leave `frz_out` set through system reset.

// File: rtl/lpdbg_pkg.sv
package lpdbg_pkg;

   typedef enum logic [1:0] {
      MODE_RUN     = 2'd0,
      MODE_SLEEP   = 2'd1,
      MODE_STOP    = 2'd2,
      MODE_STANDBY = 2'd3
   } lpdbg_mode_e;

   localparam logic [1:0] SIZE_WORD = 2'd2;

   localparam int BIT_SLEEP_EN = 0;
   localparam int BIT_STOP_EN  = 1;
   localparam int BIT_STBY_EN  = 2;
   localparam int BIT_TRC_EN   = 5;
   localparam int BIT_TRC_LO   = 6;
   localparam int TRC_MODE_W   = 2;

   function automatic logic [31:0] keep_mask();
      logic [31:0] m;
      m = '0;
      m[BIT_SLEEP_EN] = 1'b1;
      m[BIT_STOP_EN]  = 1'b1;
      m[BIT_STBY_EN]  = 1'b1;
      m[BIT_TRC_EN]   = 1'b1;
      for (int i = 0; i < TRC_MODE_W; i++) m[BIT_TRC_LO + i] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/lpdbg_cfgreg.sv
module lpdbg_cfgreg #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              sel,
   input  logic              write,
   input  logic [1:0]        size,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              err,
   output logic [DATA_W-1:0] cfg_o
);
   import lpdbg_pkg::*;

   localparam logic [DATA_W-1:0] KEEP = DATA_W'(keep_mask());

   logic              word_ok;
   logic [DATA_W-1:0] cfg_q;

   assign word_ok = (size == SIZE_WORD);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         cfg_q <= '0;
      else if (sel && write && word_ok)
         cfg_q <= wdata & KEEP;
   end

   assign rdata = (sel && word_ok) ? cfg_q : '0;
   assign err   = sel && !word_ok;
   assign cfg_o = cfg_q;

endmodule

// File: rtl/lpdbg_policy.sv
module lpdbg_policy (
   input  logic [1:0] mode,
   input  logic       sleep_en,
   input  logic       stop_en,
   input  logic       stby_en,
   output logic       core_run,
   output logic       bus_run,
   output logic       want_rc
);
   import lpdbg_pkg::*;

   always_comb begin
      core_run = 1'b1;
      bus_run  = 1'b1;
      want_rc  = 1'b0;
      case (lpdbg_mode_e'(mode))
         MODE_RUN: ;
         MODE_SLEEP: begin
            core_run = sleep_en;
         end
         MODE_STOP: begin
            core_run = stop_en;
            bus_run  = stop_en;
            want_rc  = stop_en;
         end
         MODE_STANDBY: begin
            core_run = stby_en;
            bus_run  = stby_en;
            want_rc  = stby_en;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/lpdbg_sync_leg.sv
module lpdbg_sync_leg #(
   parameter int   STAGES = 2,
   parameter logic RST_ON = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic block,
   output logic on
);
   logic [STAGES-1:0] pq;
   logic              nq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pq <= {STAGES{RST_ON}};
      else
         pq <= {pq[STAGES-2:0], req & ~block};
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)
         nq <= RST_ON;
      else
         nq <= pq[STAGES-1];
   end

   assign on = nq;

endmodule

// File: rtl/lpdbg_freeze.sv
module lpdbg_freeze #(
   parameter int NUM_FRZ = 4,
   parameter int STAGES  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               halted,
   input  logic [NUM_FRZ-1:0] cfg,
   output logic [NUM_FRZ-1:0] frz
);
   logic [STAGES-1:0] hs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hs <= '0;
      else
         hs <= {hs[STAGES-2:0], halted};
   end

   for (genvar i = 0; i < NUM_FRZ; i++) begin : g_frz
      assign frz[i] = cfg[i] & hs[STAGES-1];
   end

endmodule

// File: rtl/lpdbg_clkctl.sv
module lpdbg_clkctl #(
   parameter int DATA_W      = 32,
   parameter int NUM_FRZ     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic               dbg_clk,
   input  logic               por_n,
   input  logic               sys_rst_n,
   input  logic               sys_clk,
   input  logic               rc_clk,
   input  logic               cfg_sel,
   input  logic               cfg_write,
   input  logic [1:0]         cfg_size,
   input  logic [DATA_W-1:0]  cfg_wdata,
   output logic [DATA_W-1:0]  cfg_rdata,
   output logic               cfg_err,
   input  logic [1:0]         lp_state,
   input  logic               core_halted,
   input  logic [NUM_FRZ-1:0] frz_cfg,
   output logic               core_clk,
   output logic               bus_clk,
   output logic               clk_src,
   output logic               trace_en,
   output logic [1:0]         trace_mode,
   output logic [NUM_FRZ-1:0] frz_out
);
   import lpdbg_pkg::*;

   localparam int NUM_GATES = 2;

   if (DATA_W != 32) begin : g_bad_width
      $error("lpdbg_clkctl: DATA_W must be 32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("lpdbg_clkctl: SYNC_STAGES must be at least 2");
   end
   if (NUM_FRZ < 1) begin : g_bad_frz
      $error("lpdbg_clkctl: NUM_FRZ must be at least 1");
   end

   logic [DATA_W-1:0]    cfg_q;
   logic                 core_run, bus_run, want_rc;
   logic                 en_sys, en_rc;
   logic                 mclk;
   logic                 frz_rst_n;
   logic [NUM_GATES-1:0] gate_req, gate_on, gclk;

   lpdbg_cfgreg #(.DATA_W(DATA_W)) u_reg (
      .clk   (dbg_clk),
      .por_n (por_n),
      .sel   (cfg_sel),
      .write (cfg_write),
      .size  (cfg_size),
      .wdata (cfg_wdata),
      .rdata (cfg_rdata),
      .err   (cfg_err),
      .cfg_o (cfg_q)
   );

   lpdbg_policy u_pol (
      .mode     (lp_state),
      .sleep_en (cfg_q[BIT_SLEEP_EN]),
      .stop_en  (cfg_q[BIT_STOP_EN]),
      .stby_en  (cfg_q[BIT_STBY_EN]),
      .core_run (core_run),
      .bus_run  (bus_run),
      .want_rc  (want_rc)
   );

   lpdbg_sync_leg #(.STAGES(SYNC_STAGES), .RST_ON(1'b1)) u_leg_sys (
      .clk   (sys_clk),
      .rst_n (por_n),
      .req   (~want_rc),
      .block (en_rc),
      .on    (en_sys)
   );

   lpdbg_sync_leg #(.STAGES(SYNC_STAGES), .RST_ON(1'b0)) u_leg_rc (
      .clk   (rc_clk),
      .rst_n (por_n),
      .req   (want_rc),
      .block (en_sys),
      .on    (en_rc)
   );

   assign mclk    = (sys_clk & en_sys) | (rc_clk & en_rc);
   assign clk_src = en_rc;

   assign gate_req = {bus_run, core_run};

   for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
      lpdbg_sync_leg #(.STAGES(SYNC_STAGES), .RST_ON(1'b1)) u_gate (
         .clk   (mclk),
         .rst_n (por_n),
         .req   (gate_req[g]),
         .block (1'b0),
         .on    (gate_on[g])
      );
      assign gclk[g] = mclk & gate_on[g];
   end

   assign core_clk = gclk[0];
   assign bus_clk  = gclk[1];

   assign trace_en   = cfg_q[BIT_TRC_EN];
   assign trace_mode = cfg_q[BIT_TRC_LO +: TRC_MODE_W];

   assign frz_rst_n = por_n & sys_rst_n;

   lpdbg_freeze #(.NUM_FRZ(NUM_FRZ), .STAGES(SYNC_STAGES)) u_frz (
      .clk    (dbg_clk),
      .rst_n  (frz_rst_n),
      .halted (core_halted),
      .cfg    (frz_cfg),
      .frz    (frz_out)
   );

endmodule

// File: rtl/lpdbg_clkctl_chk.sv
module lpdbg_clkctl_chk #(
   parameter int DATA_W      = 32,
   parameter int NUM_FRZ     = 4,
   parameter int SYNC_STAGES = 2
) (
   input logic               dbg_clk,
   input logic               por_n,
   input logic               sys_rst_n,
   input logic               cfg_sel,
   input logic               cfg_write,
   input logic [1:0]         cfg_size,
   input logic [DATA_W-1:0]  cfg_rdata,
   input logic               cfg_err,
   input logic [DATA_W-1:0]  cfg_q,
   input logic               trace_en,
   input logic               en_sys,
   input logic               en_rc,
   input logic               core_halted,
   input logic [NUM_FRZ-1:0] frz_cfg,
   input logic [NUM_FRZ-1:0] frz_out
);
   import lpdbg_pkg::*;

   localparam logic [DATA_W-1:0] KEEP = DATA_W'(keep_mask());
   localparam int CW = $clog2(SYNC_STAGES + 2) + 1;

   logic [CW-1:0] quiet_cnt;

   always_ff @(posedge dbg_clk or negedge por_n) begin
      if (!por_n)
         quiet_cnt <= '0;
      else if (!sys_rst_n || core_halted)
         quiet_cnt <= '0;
      else if (quiet_cnt <= CW'(SYNC_STAGES))
         quiet_cnt <= quiet_cnt + 1'b1;
   end

   assert_src_onehot_R9: assert property (@(posedge dbg_clk) disable iff (!por_n)
      $onehot0({en_sys, en_rc}));

   assert_no_bad_write_R3: assert property (@(posedge dbg_clk) disable iff (!por_n)
      !(cfg_sel && cfg_write && cfg_size == SIZE_WORD) |=> $stable(cfg_q));

   assert_narrow_err_R3: assert property (@(posedge dbg_clk) disable iff (!por_n)
      (cfg_sel && cfg_size != SIZE_WORD) |-> (cfg_err && cfg_rdata == '0));

   assert_word_no_err_R3: assert property (@(posedge dbg_clk) disable iff (!por_n)
      (cfg_sel && cfg_size == SIZE_WORD) |-> !cfg_err);

   assert_reserved_zero_R4: assert property (@(posedge dbg_clk) disable iff (!por_n)
      ((cfg_q & ~KEEP) == '0) && ((cfg_rdata & ~KEEP) == '0));

   assert_trace_read_R4: assert property (@(posedge dbg_clk) disable iff (!por_n)
      (cfg_sel && cfg_size == SIZE_WORD) |-> (cfg_rdata[BIT_TRC_EN] == trace_en));

   assert_freeze_needs_cfg_R10: assert property (@(posedge dbg_clk) disable iff (!por_n)
      (frz_out & ~frz_cfg) == '0);

   assert_freeze_quiet_R10: assert property (@(posedge dbg_clk) disable iff (!por_n)
      (quiet_cnt > CW'(SYNC_STAGES)) |-> (frz_out == '0));

endmodule

bind lpdbg_clkctl lpdbg_clkctl_chk #(
   .DATA_W(DATA_W), .NUM_FRZ(NUM_FRZ), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .dbg_clk     (dbg_clk),
   .por_n       (por_n),
   .sys_rst_n   (sys_rst_n),
   .cfg_sel     (cfg_sel),
   .cfg_write   (cfg_write),
   .cfg_size    (cfg_size),
   .cfg_rdata   (cfg_rdata),
   .cfg_err     (cfg_err),
   .cfg_q       (cfg_q),
   .trace_en    (trace_en),
   .en_sys      (en_sys),
   .en_rc       (en_rc),
   .core_halted (core_halted),
   .frz_cfg     (frz_cfg),
   .frz_out     (frz_out)
);

// File: tb/sim_lpdbg_clkctl.sv
`timescale 1ns/1ps
module sim_lpdbg_clkctl;

   localparam int NF = 4;
   localparam int SS = 2;

   logic          dbg_clk = 1'b0, sys_clk = 1'b0, rc_clk = 1'b0;
   logic          por_n = 1'b0, sys_rst_n = 1'b0;
   logic          cfg_sel = 1'b0, cfg_write = 1'b0;
   logic [1:0]    cfg_size = 2'd2;
   logic [31:0]   cfg_wdata = '0;
   logic [31:0]   cfg_rdata;
   logic          cfg_err;
   logic [1:0]    lp_state = 2'd0;
   logic          core_halted = 1'b0;
   logic [NF-1:0] frz_cfg = '0;
   logic          core_clk, bus_clk, clk_src, trace_en;
   logic [1:0]    trace_mode;
   logic [NF-1:0] frz_out;

   int errors = 0;
   int checks = 0;
   int core_cnt = 0;
   int bus_cnt = 0;

   always #2.5 sys_clk = ~sys_clk;
   always #2.5 dbg_clk = ~dbg_clk;
   always #13  rc_clk  = ~rc_clk;

   always @(posedge core_clk) core_cnt++;
   always @(posedge bus_clk)  bus_cnt++;

   lpdbg_clkctl #(.DATA_W(32), .NUM_FRZ(NF), .SYNC_STAGES(SS)) u0 (
      .dbg_clk(dbg_clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
      .sys_clk(sys_clk), .rc_clk(rc_clk),
      .cfg_sel(cfg_sel), .cfg_write(cfg_write), .cfg_size(cfg_size),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
      .lp_state(lp_state), .core_halted(core_halted), .frz_cfg(frz_cfg),
      .core_clk(core_clk), .bus_clk(bus_clk), .clk_src(clk_src),
      .trace_en(trace_en), .trace_mode(trace_mode), .frz_out(frz_out)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic [31:0] d, input logic [1:0] sz);
      @(negedge dbg_clk);
      cfg_sel = 1'b1; cfg_write = 1'b1; cfg_size = sz; cfg_wdata = d;
      @(negedge dbg_clk);
      cfg_sel = 1'b0; cfg_write = 1'b0; cfg_size = 2'd2;
   endtask

   task automatic bus_read(input logic [1:0] sz, output logic [31:0] d, output logic e);
      @(negedge dbg_clk);
      cfg_sel = 1'b1; cfg_write = 1'b0; cfg_size = sz;
      #1;
      d = cfg_rdata; e = cfg_err;
      @(negedge dbg_clk);
      cfg_sel = 1'b0; cfg_size = 2'd2;
   endtask

   // kind: 0 stopped, 1 sys_clk rate, 2 rc_clk rate (400 ns window)
   function automatic bit rate_ok(input int cnt, input int kind);
      if (kind == 0) return cnt == 0;
      if (kind == 1) return cnt >= 78 && cnt <= 82;
      return cnt >= 14 && cnt <= 17;
   endfunction

   task automatic clocks_expect(input string req, input logic [1:0] st,
                                input int core_k, input int bus_k, input logic src);
      lp_state = st;
      #300;
      core_cnt = 0; bus_cnt = 0;
      #400;
      chk(rate_ok(core_cnt, core_k), req, "core_clk edges", core_cnt, core_k);
      chk(rate_ok(bus_cnt, bus_k), req, "bus_clk edges", bus_cnt, bus_k);
      chk(clk_src == src, req, "clk_src", clk_src, src);
   endtask

   task automatic t_reset_state();
      logic [31:0] d; logic e;
      por_n = 1'b0; sys_rst_n = 1'b0;
      #40; por_n = 1'b1;
      bus_read(2'd2, d, e);
      chk(d == 32'h0, "R1", "word after power-on reset", d, 0);
      chk(!trace_en && trace_mode == 2'd0, "R1", "trace outputs after reset",
          {trace_mode, trace_en}, 0);
   endtask

   task automatic t_sysreset_domain();
      logic [31:0] d; logic e;
      bus_write(32'hFFFF_FFFF, 2'd2);      // still under system reset
      bus_read(2'd2, d, e);
      chk(d == 32'h0000_00E7, "R2", "write under system reset", d, 32'hE7);
      chk(d == 32'h0000_00E7, "R4", "reserved bits read zero", d, 32'hE7);
      sys_rst_n = 1'b1; #20; sys_rst_n = 1'b0; #20; sys_rst_n = 1'b1;
      bus_read(2'd2, d, e);
      chk(d == 32'h0000_00E7, "R2", "word kept over system reset", d, 32'hE7);
      chk(trace_en && trace_mode == 2'd3, "R4", "trace outputs all ones",
          {trace_mode, trace_en}, 3'b111);
   endtask

   task automatic t_access_size();
      logic [31:0] d; logic e;
      bus_write(32'h0, 2'd0);
      bus_write(32'h0, 2'd1);
      bus_read(2'd2, d, e);
      chk(d == 32'h0000_00E7, "R3", "narrow writes ignored", d, 32'hE7);
      chk(!e, "R3", "word access error", e, 0);
      bus_read(2'd0, d, e);
      chk(e && d == 0, "R3", "byte read error/data", {e, d}, 33'h1_0000_0000);
      bus_write(32'h0000_0060, 2'd2);
      bus_read(2'd2, d, e);
      chk(d == 32'h0000_0060 && trace_en && trace_mode == 2'd1, "R4",
          "trace enable and mode 1", d, 32'h60);
      por_n = 1'b0; #10; por_n = 1'b1;
      bus_read(2'd2, d, e);
      chk(d == 32'h0, "R1", "power-on reset clears word", d, 0);
   endtask

   task automatic t_clocks_disabled();
      bus_write(32'h0, 2'd2);
      clocks_expect("R5", 2'd0, 1, 1, 1'b0);
      clocks_expect("R6", 2'd1, 0, 1, 1'b0);
      clocks_expect("R7", 2'd2, 0, 0, 1'b0);
      clocks_expect("R8", 2'd3, 0, 0, 1'b0);
      clocks_expect("R5", 2'd0, 1, 1, 1'b0);
   endtask

   task automatic t_clocks_enabled();
      bus_write(32'h0000_0007, 2'd2);
      clocks_expect("R6", 2'd1, 1, 1, 1'b0);
      clocks_expect("R7", 2'd2, 2, 2, 1'b1);
      clocks_expect("R9", 2'd0, 1, 1, 1'b0);
      clocks_expect("R8", 2'd3, 2, 2, 1'b1);
      clocks_expect("R9", 2'd1, 1, 1, 1'b0);
      bus_write(32'h0000_0002, 2'd2);
      clocks_expect("R8", 2'd3, 0, 0, 1'b0);
      clocks_expect("R7", 2'd2, 2, 2, 1'b1);
      clocks_expect("R9", 2'd0, 1, 1, 1'b0);
   endtask

   task automatic t_freeze();
      frz_cfg = 4'b0101;
      @(negedge dbg_clk); core_halted = 1'b1;
      repeat (SS - 1) @(posedge dbg_clk);
      @(negedge dbg_clk);
      chk(frz_out == 4'b0000, "R10", "freeze not yet through sync", frz_out, 0);
      @(posedge dbg_clk); @(negedge dbg_clk);
      chk(frz_out == 4'b0101, "R10", "freeze after sync", frz_out, 4'b0101);
      frz_cfg = 4'b1010; #1;
      chk(frz_out == 4'b1010, "R10", "freeze follows selection", frz_out, 4'b1010);
      @(negedge dbg_clk); core_halted = 1'b0;
      repeat (SS + 1) @(posedge dbg_clk);
      @(negedge dbg_clk);
      chk(frz_out == 4'b0000, "R10", "release after halt ends", frz_out, 0);
      core_halted = 1'b1;
      repeat (SS + 1) @(posedge dbg_clk);
      @(negedge dbg_clk);
      sys_rst_n = 1'b0; #1;
      chk(frz_out == 4'b0000, "R10", "freeze cleared by system reset", frz_out, 0);
      @(negedge dbg_clk); sys_rst_n = 1'b1; core_halted = 1'b0;
   endtask

   initial begin
      #500_000;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset_state();
      t_sysreset_domain();
      t_access_size();
      t_clocks_disabled();
      t_clocks_enabled();
      t_freeze();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule